// File: doc/BRIEF.md
# PLL-Aware Reset Sequencer

This block orders the resets of a small system that runs from a PLL. A push button and a PLL lock flag come in; two active-high reset outputs go out. The first output holds the PLL in reset for a counted number of external-clock cycles after power-up or after the button is let go. The second output, made in the PLL clock domain, keeps the rest of the system in reset until the PLL reset has dropped, lock is reported, and a second counted delay has run out.

The button and the lock flag are each brought through a two-flop synchroniser in the clock domain that uses them. A button press therefore reaches both outputs through synchronisers, never through a combinational path. Losing lock while the system runs puts the system back in reset and starts its delay again. Each delay counter counts up from zero to all-ones and stops there. Any new reset condition sets it back to zero. The button polarity is set by a parameter.

Top module: `pll_reset_sequencer`

## Requirements
- R1: At power-up both outputs read 1. With the button released from time zero, `pll_rst` reads 1 after external-clock edges 1 to 5 and 0 from edge 6 on (default counter width 2).
- R2: With `BTN_ACTIVE_LOW` = 1 a 0 on `btn_in` means pressed. With `BTN_ACTIVE_LOW` = 0 a 1 means pressed. Both settings give the same output timing for the same press.
- R3: `sys_rst` stays 1 for as long as the synchronised lock is low, whatever the state of the PLL reset.
- R4: With `pll_rst` already low, lock going high before PLL-clock edge k releases `sys_rst` after edge k+5 and not earlier.
- R5: `sys_rst` falls on the sixth PLL-clock edge after the edge on which `pll_rst` falls, provided lock stays high.
- R6: With both resets released, a press seen first at edge k sets both outputs to 1 after edge k+2. Both still read 0 after edges k and k+1.
- R7: A release seen first at edge k+D, after a press of D cycles, leaves `pll_rst` at 1 through edge k+D+4 and drops it after edge k+D+5. This also holds for a one-cycle press.
- R8: A lock loss of L cycles seen first at edge k sets `sys_rst` to 1 after edge k+2 and keeps it there through edge k+L+4. `sys_rst` drops after edge k+L+5.
- R9: Once the delays have expired, both counters hold at all-ones and both outputs stay 0 for as long as the inputs stay quiet.
- R10: `pll_rst` does not depend on the lock input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_clk | input | 1 | External reference clock; samples the button |
| pll_clk | input | 1 | PLL output clock; clocks the system-reset logic |
| lock_in | input | 1 | PLL lock flag, asynchronous |
| btn_in | input | 1 | Reset button, polarity set by `BTN_ACTIVE_LOW` |
| pll_rst | output | 1 | Reset to the PLL, 1 = in reset |
| sys_rst | output | 1 | System reset in the PLL domain, 1 = in reset |

## Verification
Power-up is run with the button released and lock held off. This shows that the PLL delay and the lock gate are separate, and that the lock gate does not drop early. Presses of one to eight cycles are swept, and so are lock losses of one to four cycles. Every output sample is compared against arithmetic edge counts, which catches an off-by-one in the synchronisers or in the counters. A second instance with the opposite polarity sees every press as its inverse, and must match the first instance on every sample.

// File: rtl/pll_reset_sequencer.sv
module pll_reset_sequencer #(
  parameter int PLL_CNT_W      = 2,
  parameter int SYS_CNT_W      = 2,
  parameter bit BTN_ACTIVE_LOW = 1'b1
) (
  input  logic ext_clk,
  input  logic pll_clk,
  input  logic lock_in,
  input  logic btn_in,
  output logic pll_rst,
  output logic sys_rst
);

  localparam logic [PLL_CNT_W-1:0] PLL_ONE = PLL_CNT_W'(1);
  localparam logic [SYS_CNT_W-1:0] SYS_ONE = SYS_CNT_W'(1);

  logic press_raw;
  assign press_raw = BTN_ACTIVE_LOW ? ~btn_in : btn_in;

  // external clock domain
  logic [1:0]           e_btn = 2'b11;
  logic [PLL_CNT_W-1:0] e_cnt = '0;
  logic                 e_rst = 1'b1;
  logic                 e_up  = 1'b0;

  always_ff @(posedge ext_clk) begin
    e_up  <= 1'b1;
    e_btn <= {e_btn[0], press_raw};
    if (e_btn[1])
      e_cnt <= '0;
    else if (e_cnt != '1)
      e_cnt <= e_cnt + PLL_ONE;
    e_rst <= e_btn[1] | (e_cnt != '1);
  end

  assign pll_rst = e_rst;

  // PLL clock domain
  logic [1:0]           p_btn  = 2'b11;
  logic [1:0]           p_prst = 2'b11;
  logic [1:0]           p_lock = 2'b00;
  logic [SYS_CNT_W-1:0] p_cnt  = '0;
  logic                 p_rst  = 1'b1;
  logic                 p_up   = 1'b0;
  logic                 p_hold;

  assign p_hold = p_btn[1] | p_prst[1] | ~p_lock[1];

  always_ff @(posedge pll_clk) begin
    p_up   <= 1'b1;
    p_btn  <= {p_btn[0], press_raw};
    p_prst <= {p_prst[0], e_rst};
    p_lock <= {p_lock[0], lock_in};
    if (p_hold)
      p_cnt <= '0;
    else if (p_cnt != '1)
      p_cnt <= p_cnt + SYS_ONE;
    p_rst <= p_hold | (p_cnt != '1);
  end

  assign sys_rst = p_rst;

  a_r6_press_sets_pll_rst: assert property (@(posedge ext_clk) disable iff (!e_up)
    e_btn[1] |=> pll_rst);

  a_r9_pll_cnt_holds: assert property (@(posedge ext_clk) disable iff (!e_up)
    (e_cnt == '1 && !e_btn[1]) |=> (e_cnt == '1));

  a_r7_pll_rst_falls_after_count: assert property (@(posedge ext_clk) disable iff (!e_up)
    $fell(pll_rst) |-> ($past(e_cnt) == '1 && !$past(e_btn[1])));

  a_r3_no_lock_keeps_sys_rst: assert property (@(posedge pll_clk) disable iff (!p_up)
    !p_lock[1] |=> sys_rst);

  a_r5_pll_rst_keeps_sys_rst: assert property (@(posedge pll_clk) disable iff (!p_up)
    p_prst[1] |=> sys_rst);

  a_r9_sys_cnt_holds: assert property (@(posedge pll_clk) disable iff (!p_up)
    (p_cnt == '1 && !p_hold) |=> (p_cnt == '1));

endmodule

// File: tb/pll_reset_sequencer_tb_top.sv
module pll_reset_sequencer_tb_top;

  logic clk = 1'b0;
  logic lock = 1'b0;
  logic btn_n = 1'b1;
  logic pll_rst, sys_rst, pll_rst_h, sys_rst_h;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pll_reset_sequencer dut_i (
    .ext_clk(clk), .pll_clk(clk), .lock_in(lock), .btn_in(btn_n),
    .pll_rst(pll_rst), .sys_rst(sys_rst));

  pll_reset_sequencer #(.BTN_ACTIVE_LOW(1'b0)) dut_h_i (
    .ext_clk(clk), .pll_clk(clk), .lock_in(lock), .btn_in(~btn_n),
    .pll_rst(pll_rst_h), .sys_rst(sys_rst_h));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic ep, input logic es);
    chk(req, "pll_rst", pll_rst, ep);
    chk(req, "sys_rst", sys_rst, es);
    chk("R2", "pll_rst active-high copy", pll_rst_h, ep);
    chk("R2", "sys_rst active-high copy", sys_rst_h, es);
  endtask

  initial begin
    #1;
    chk_all("R1", 1'b1, 1'b1);
    // R1 power-up, R3 lock low, R10 pll_rst ignores lock
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      chk_all("R1", j < 6, 1'b1);
    end
    lock = 1'b1;
    // R4 lock rises, edge k = 13
    for (int i = 0; i <= 10; i++) begin
      @(negedge clk);
      chk_all("R4", 1'b0, i < 5);
    end
    // R6 and R7 sweep over press lengths; R5 tracked by the sys_rst release
    for (int d = 1; d <= 8; d++) begin
      btn_n = 1'b0;
      for (int i = 0; i <= d + 14; i++) begin
        @(negedge clk);
        if (i < 2) chk_all("R6", 1'b0, 1'b0);
        else if (i < d + 5) chk_all("R7", 1'b1, 1'b1);
        else chk_all("R5", 1'b0, i < d + 11);
        if (i == d - 1) btn_n = 1'b1;
      end
    end
    // R8 lock loss sweep, R10 pll_rst unaffected
    for (int l = 1; l <= 4; l++) begin
      lock = 1'b0;
      for (int i = 0; i <= l + 10; i++) begin
        @(negedge clk);
        chk_all("R8", 1'b0, (i >= 2) && (i < l + 5));
        if (i == l - 1) lock = 1'b1;
      end
    end
    // R9 long quiet run
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk_all("R9", 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule